// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle load/store processor. Its states are not coded as a hand-written state machine. It keeps a microprogram counter that indexes a small constant control store. Each cycle it reads one microinstruction, and the fields of that word drive the datapath controls directly: ALU operation, the two ALU source selects, register-file action, memory action and PC write. A sequencing field in the same word chooses the next micro-address from four options: advance by one, jump through one of two opcode-indexed dispatch tables, or go back to the fetch entry.

The opcode of the instruction in flight is an input. It only matters in the two cycles whose sequencing field names a dispatch table. An opcode with no entry in the table in use sends the sequencer to a dedicated entry. That entry raises an undefined-instruction flag, leaves the datapath idle and then returns to fetch. The datapath sees the same control pattern, cycle for cycle, that an equivalent hand-drawn state machine would give it.

Control outputs are read combinationally from the store at the registered micro-address. The micro-address changes on the rising clock edge.

Top module: `useq_top`

## Requirements
- R1: A high synchronous `rst` at a rising edge sets `upc` to 0, the fetch entry, whatever the opcode or the current state. This includes a reset that arrives in a dispatch cycle.
- R2: At `upc`=0 the outputs are alu_op=0 (add), alu_src1=0 (PC), alu_src2=1 (constant 4), rf_ctl=0, mem_ctl=1 (read at PC), pc_wr=1 (ALU result), and the next `upc` is 1.
- R3: At `upc`=1 the outputs are alu_op=0, alu_src1=0, alu_src2=3 (shifted sign-extended immediate), rf_ctl=1 (read), mem_ctl=0, pc_wr=0. The next address comes from dispatch table 1.
- R4: Dispatch table 1 maps opcode 6'h00 to 6, 6'h23 to 2, 6'h2B to 2, 6'h04 to 8 and 6'h02 to 9.
- R5: At `upc`=2 the outputs are alu_op=0, alu_src1=1 (register A), alu_src2=2 (sign-extended immediate), and all other fields are 0. Dispatch table 2 maps 6'h23 to 3 and 6'h2B to 5.
- R6: Load path: `upc`=3 drives mem_ctl=2 (read at ALU result) and advances to 4. `upc`=4 drives rf_ctl=3 (write memory data) and returns to 0.
- R7: Store step: `upc`=5 drives mem_ctl=3 (write at ALU result) and returns to 0.
- R8: R-type path: `upc`=6 drives alu_op=2 (function field), alu_src1=1, alu_src2=0 (register B) and advances to 7. `upc`=7 drives rf_ctl=2 (write ALU result) and returns to 0.
- R9: `upc`=8 drives alu_op=1 (subtract), alu_src1=1, alu_src2=0, pc_wr=2 (conditional). `upc`=9 drives pc_wr=3 (jump target). Both return to 0.
- R10: An opcode with no entry in the dispatch table in use leads to `upc`=10. There `undef_instr`=1 and every other field is 0. The next `upc` is 0.
- R11: `undef_instr` is 0 in every state other than 10.
- R12: The opcode has no effect on the next address in any state whose sequencing is not a dispatch.
- In every state above, any field not named is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode of the current instruction |
| alu_op | output | 2 | 0 add, 1 subtract, 2 by function field |
| alu_src1 | output | 1 | 0 PC, 1 register A |
| alu_src2 | output | 2 | 0 register B, 1 constant 4, 2 immediate, 3 shifted immediate |
| rf_ctl | output | 2 | 0 idle, 1 read, 2 write ALU result, 3 write memory data |
| mem_ctl | output | 2 | 0 idle, 1 read at PC, 2 read at ALU result, 3 write at ALU result |
| pc_wr | output | 2 | 0 none, 1 ALU result, 2 conditional, 3 jump target |
| undef_instr | output | 1 | Undefined-instruction flag |
| upc | output | 4 | Current micro-address |

## Verification
Two things can land on the same edge: a reset and a dispatch decision. The bench holds a valid load opcode in the decode cycle and raises reset in that same cycle. It then checks that `upc` is 0 after the edge rather than the dispatch target. A second collision pits the opcode-fed dispatch against a changing opcode. The opcode is switched between the decode and memory-address cycles so that table 2 misses. The run passes only if the sequence ends at the undefined entry, while changes in non-dispatch cycles leave the path unchanged.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W = 6;
    localparam int UA_W  = 4;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2
    } alu_op_e;

    typedef enum logic {
        S1_PC   = 1'b0,
        S1_REGA = 1'b1
    } src1_e;

    typedef enum logic [1:0] {
        S2_REGB   = 2'd0,
        S2_FOUR   = 2'd1,
        S2_IMM    = 2'd2,
        S2_IMM_SH = 2'd3
    } src2_e;

    typedef enum logic [1:0] {
        RF_IDLE   = 2'd0,
        RF_READ   = 2'd1,
        RF_WR_ALU = 2'd2,
        RF_WR_MDR = 2'd3
    } rf_e;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'd0,
        MEM_FETCH = 2'd1,
        MEM_LOAD  = 2'd2,
        MEM_STORE = 2'd3
    } mem_e;

    typedef enum logic [1:0] {
        PCW_NONE = 2'd0,
        PCW_ALU  = 2'd1,
        PCW_COND = 2'd2,
        PCW_JUMP = 2'd3
    } pcw_e;

    typedef enum logic [1:0] {
        SEQ_INC   = 2'd0,
        SEQ_DISP1 = 2'd1,
        SEQ_DISP2 = 2'd2,
        SEQ_FETCH = 2'd3
    } seq_e;

    // 14-bit microinstruction word
    typedef struct packed {
        alu_op_e alu;
        src1_e   s1;
        src2_e   s2;
        rf_e     rf;
        mem_e    mem;
        pcw_e    pcw;
        logic    undef;
        seq_e    seq;
    } uword_t;

    typedef struct packed {
        logic [UA_W-1:0] upc;
    } seq_state_t;

    // micro-address labels
    localparam logic [UA_W-1:0] UA_FETCH   = 4'd0;
    localparam logic [UA_W-1:0] UA_DECODE  = 4'd1;
    localparam logic [UA_W-1:0] UA_MADDR   = 4'd2;
    localparam logic [UA_W-1:0] UA_LD_RD   = 4'd3;
    localparam logic [UA_W-1:0] UA_LD_WB   = 4'd4;
    localparam logic [UA_W-1:0] UA_ST_WR   = 4'd5;
    localparam logic [UA_W-1:0] UA_RR_EX   = 4'd6;
    localparam logic [UA_W-1:0] UA_RR_WB   = 4'd7;
    localparam logic [UA_W-1:0] UA_BRANCH  = 4'd8;
    localparam logic [UA_W-1:0] UA_JUMP    = 4'd9;
    localparam logic [UA_W-1:0] UA_ILLEGAL = 4'd10;

    // opcode values decoded by the dispatch tables
    localparam logic [OPC_W-1:0] OP_RR   = 6'h00;
    localparam logic [OPC_W-1:0] OP_JMP  = 6'h02;
    localparam logic [OPC_W-1:0] OP_BEQ  = 6'h04;
    localparam logic [OPC_W-1:0] OP_LOAD = 6'h23;
    localparam logic [OPC_W-1:0] OP_STOR = 6'h2B;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);

    function automatic uword_t mk(alu_op_e a, src1_e s1, src2_e s2, rf_e rf,
                                  mem_e m, pcw_e p, logic u, seq_e q);
        uword_t w;
        w.alu   = a;
        w.s1    = s1;
        w.s2    = s2;
        w.rf    = rf;
        w.mem   = m;
        w.pcw   = p;
        w.undef = u;
        w.seq   = q;
        return w;
    endfunction

    always_comb begin
        case (addr)
            UA_FETCH:  word = mk(ALU_ADD, S1_PC, S2_FOUR, RF_IDLE, MEM_FETCH, PCW_ALU, 1'b0, SEQ_INC);
            UA_DECODE: word = mk(ALU_ADD, S1_PC, S2_IMM_SH, RF_READ, MEM_IDLE, PCW_NONE, 1'b0, SEQ_DISP1);
            UA_MADDR:  word = mk(ALU_ADD, S1_REGA, S2_IMM, RF_IDLE, MEM_IDLE, PCW_NONE, 1'b0, SEQ_DISP2);
            UA_LD_RD:  word = mk(ALU_ADD, S1_PC, S2_REGB, RF_IDLE, MEM_LOAD, PCW_NONE, 1'b0, SEQ_INC);
            UA_LD_WB:  word = mk(ALU_ADD, S1_PC, S2_REGB, RF_WR_MDR, MEM_IDLE, PCW_NONE, 1'b0, SEQ_FETCH);
            UA_ST_WR:  word = mk(ALU_ADD, S1_PC, S2_REGB, RF_IDLE, MEM_STORE, PCW_NONE, 1'b0, SEQ_FETCH);
            UA_RR_EX:  word = mk(ALU_FUNCT, S1_REGA, S2_REGB, RF_IDLE, MEM_IDLE, PCW_NONE, 1'b0, SEQ_INC);
            UA_RR_WB:  word = mk(ALU_ADD, S1_PC, S2_REGB, RF_WR_ALU, MEM_IDLE, PCW_NONE, 1'b0, SEQ_FETCH);
            UA_BRANCH: word = mk(ALU_SUB, S1_REGA, S2_REGB, RF_IDLE, MEM_IDLE, PCW_COND, 1'b0, SEQ_FETCH);
            UA_JUMP:   word = mk(ALU_ADD, S1_PC, S2_REGB, RF_IDLE, MEM_IDLE, PCW_JUMP, 1'b0, SEQ_FETCH);
            // the illegal entry and every unused slot: flag, stay idle, refetch
            default:   word = mk(ALU_ADD, S1_PC, S2_REGB, RF_IDLE, MEM_IDLE, PCW_NONE, 1'b1, SEQ_FETCH);
        endcase
    end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE_ID = 1
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  target
);

    generate
        if (TABLE_ID == 1) begin : g_tab1
            always_comb begin
                case (opcode)
                    OP_RR:   target = UA_RR_EX;
                    OP_LOAD: target = UA_MADDR;
                    OP_STOR: target = UA_MADDR;
                    OP_BEQ:  target = UA_BRANCH;
                    OP_JMP:  target = UA_JUMP;
                    default: target = UA_ILLEGAL;
                endcase
            end
        end else begin : g_tab2
            always_comb begin
                case (opcode)
                    OP_LOAD: target = UA_LD_RD;
                    OP_STOR: target = UA_ST_WR;
                    default: target = UA_ILLEGAL;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  seq_e            seq,
    input  logic [UA_W-1:0] upc,
    input  logic [UA_W-1:0] tgt1,
    input  logic [UA_W-1:0] tgt2,
    output logic [UA_W-1:0] nxt
);

    localparam logic [UA_W-1:0] ONE = {{(UA_W-1){1'b0}}, 1'b1};

    always_comb begin
        case (seq)
            SEQ_INC:   nxt = upc + ONE;
            SEQ_DISP1: nxt = tgt1;
            SEQ_DISP2: nxt = tgt2;
            default:   nxt = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic [1:0]       alu_op,
    output logic             alu_src1,
    output logic [1:0]       alu_src2,
    output logic [1:0]       rf_ctl,
    output logic [1:0]       mem_ctl,
    output logic [1:0]       pc_wr,
    output logic             undef_instr,
    output logic [UA_W-1:0]  upc
);

    seq_state_t      st_d, st_q;
    uword_t          word;
    logic [UA_W-1:0] tgt1, tgt2, nxt;

    useq_rom u_rom (
        .addr (st_q.upc),
        .word (word)
    );

    useq_dispatch #(.TABLE_ID(1)) u_disp1 (
        .opcode (opcode),
        .target (tgt1)
    );

    useq_dispatch #(.TABLE_ID(2)) u_disp2 (
        .opcode (opcode),
        .target (tgt2)
    );

    useq_next u_next (
        .seq  (word.seq),
        .upc  (st_q.upc),
        .tgt1 (tgt1),
        .tgt2 (tgt2),
        .nxt  (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
        if (rst) begin
            st_d.upc = UA_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign alu_op      = word.alu;
    assign alu_src1    = word.s1;
    assign alu_src2    = word.s2;
    assign rf_ctl      = word.rf;
    assign mem_ctl     = word.mem;
    assign pc_wr       = word.pcw;
    assign undef_instr = word.undef;
    assign upc         = st_q.upc;

    // reset lands on fetch, whatever state or opcode
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (upc == UA_FETCH));

    // fetch word is fixed and always followed by decode
    p_fetch_word_r2: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |-> (mem_ctl == 2'd1 && pc_wr == 2'd1 && alu_src2 == 2'd1));
    p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |=> (upc == UA_DECODE));

    // decode dispatches loads and stores to the address step
    p_decode_mem_r4: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_DECODE && (opcode == OP_LOAD || opcode == OP_STOR)) |=> (upc == UA_MADDR));

    // load read step is followed by its writeback
    p_load_step_r6: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_LD_RD) |=> (upc == UA_LD_WB));

    // illegal entry goes back to fetch
    p_illegal_ret_r10: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_ILLEGAL) |=> (upc == UA_FETCH));

    // flag only in the illegal entry
    p_undef_only_r11: assert property (@(posedge clk) disable iff (rst)
        undef_instr |-> (upc == UA_ILLEGAL));

    // straight-line steps ignore the opcode
    p_opcode_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_RR_EX) |=> (upc == UA_RR_WB));

endmodule

// File: tb/useq_top_bench.sv
module useq_top_bench;

    localparam int CLK_P = 20;
    localparam int NVEC  = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [1:0] alu_op, alu_src2, rf_ctl, mem_ctl, pc_wr;
    logic       alu_src1, undef_instr;
    logic [3:0] upc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    useq_top u_useq_top (
        .clk         (clk),
        .rst         (rst),
        .opcode      (opcode),
        .alu_op      (alu_op),
        .alu_src1    (alu_src1),
        .alu_src2    (alu_src2),
        .rf_ctl      (rf_ctl),
        .mem_ctl     (mem_ctl),
        .pc_wr       (pc_wr),
        .undef_instr (undef_instr),
        .upc         (upc)
    );

    // {op0, op1, op2, steps, path[4] .. path[0]}
    localparam logic [40:0] VEC [NVEC] = '{
        {6'h23, 6'h23, 6'h23, 3'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
        {6'h2B, 6'h2B, 6'h2B, 3'd4, 4'd0, 4'd5, 4'd2, 4'd1, 4'd0},
        {6'h00, 6'h00, 6'h00, 3'd4, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0},
        {6'h04, 6'h04, 6'h04, 3'd3, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0},
        {6'h02, 6'h02, 6'h02, 3'd3, 4'd0, 4'd0, 4'd9, 4'd1, 4'd0},
        {6'h3F, 6'h3F, 6'h3F, 3'd3, 4'd0, 4'd0, 4'd10, 4'd1, 4'd0},
        {6'h23, 6'h23, 6'h00, 3'd4, 4'd0, 4'd10, 4'd2, 4'd1, 4'd0},
        {6'h3F, 6'h00, 6'h3F, 3'd4, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0},
        {6'h11, 6'h2B, 6'h2B, 3'd4, 4'd0, 4'd5, 4'd2, 4'd1, 4'd0}
    };

    // expected {alu_op, src1, src2, rf, mem, pcw, undef} per requirement
    function automatic logic [11:0] exp_ctl(input logic [3:0] a);
        case (a)
            4'd0:    return {2'd0, 1'd0, 2'd1, 2'd0, 2'd1, 2'd1, 1'b0};
            4'd1:    return {2'd0, 1'd0, 2'd3, 2'd1, 2'd0, 2'd0, 1'b0};
            4'd2:    return {2'd0, 1'd1, 2'd2, 2'd0, 2'd0, 2'd0, 1'b0};
            4'd3:    return {2'd0, 1'd0, 2'd0, 2'd0, 2'd2, 2'd0, 1'b0};
            4'd4:    return {2'd0, 1'd0, 2'd0, 2'd3, 2'd0, 2'd0, 1'b0};
            4'd5:    return {2'd0, 1'd0, 2'd0, 2'd0, 2'd3, 2'd0, 1'b0};
            4'd6:    return {2'd2, 1'd1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0};
            4'd7:    return {2'd0, 1'd0, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0};
            4'd8:    return {2'd1, 1'd1, 2'd0, 2'd0, 2'd0, 2'd2, 1'b0};
            4'd9:    return {2'd0, 1'd0, 2'd0, 2'd0, 2'd0, 2'd3, 1'b0};
            default: return {2'd0, 1'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0:       return "R2";
            4'd1:       return "R4";
            4'd2:       return "R5";
            4'd3, 4'd4: return "R6";
            4'd5:       return "R7";
            4'd6, 4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            default:    return "R10";
        endcase
    endfunction

    function automatic logic [11:0] act_ctl();
        return {alu_op, alu_src1, alu_src2, rf_ctl, mem_ctl, pc_wr, undef_instr};
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string req, input logic [3:0] a);
        chk(req, {8'd0, upc}, {8'd0, a});
        if (undef_instr && a != 4'd10)
            chk("R11", act_ctl(), exp_ctl(a));
        else
            chk(req, act_ctl(), exp_ctl(a));
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset held with a stray opcode
        opcode = 6'h3F;
        repeat (3) @(negedge clk);
        #1;
        chk_state("R1", 4'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk_state("R2", 4'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state("R1", 4'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [5:0]  op0, op1, op2;
            logic [2:0]  n;
            logic [19:0] path;
            string       tag;
            op0  = VEC[v][40:35];
            op1  = VEC[v][34:29];
            op2  = VEC[v][28:23];
            n    = VEC[v][22:20];
            path = VEC[v][19:0];
            for (int i = 0; i < int'(n); i++) begin
                opcode = (i == 0) ? op0 : ((i == 1) ? op1 : op2);
                #1;
                if (v == 7)
                    tag = "R12";
                else if (i == 0)
                    tag = "R2";
                else
                    tag = req_of(path[4*(i-1) +: 4]);
                chk_state(tag, path[4*i +: 4]);
                @(negedge clk);
            end
            #1;
            chk_state(req_of(path[4*(int'(n)-1) +: 4]), 4'd0);
        end

        // R1: reset collides with a dispatch from decode
        opcode = 6'h23;
        @(negedge clk);
        #1;
        chk_state("R3", 4'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state("R1", 4'd0);

        // R1: reset in the load writeback step
        repeat (4) @(negedge clk);
        #1;
        chk_state("R6", 4'd4);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state("R1", 4'd0);

        // R12: opcode toggles through the load steps do not redirect
        opcode = 6'h23;
        repeat (2) @(negedge clk);
        #1;
        chk_state("R5", 4'd2);
        @(negedge clk);
        opcode = 6'h00;
        #1;
        chk_state("R12", 4'd3);
        @(negedge clk);
        opcode = 6'h3F;
        #1;
        chk_state("R12", 4'd4);
        @(negedge clk);
        #1;
        chk_state("R12", 4'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule